// File: doc/BRIEF.md
# DMA Bus-Request Gate with Interrupt Hold and Nesting Suppress Counter

This block sits between the request logic of one DMA channel and the bus controller. A pending-transfer strobe carries a block count. The block latches the request and raises a bus request toward the bus controller. Once the grant arrives, it counts down the completed blocks until the last one finishes.

Two mechanisms can hold the channel off the bus. The first is automatic: a non-maskable interrupt, or a pending interrupt more urgent than a programmed threshold, makes the block withdraw its bus request. Withdrawal waits for the end of the block in flight and never cuts a block short. The request stays latched, and the bus request comes back as soon as the interrupt goes away.

The second mechanism is controlled by software. A 4-bit suppress counter can be written directly, or stepped up and down by one, so that nested interrupt handlers can each add one on entry and remove one on exit. While the counter is nonzero no bus request is raised. Requests are allowed again in the same cycle the counter reads zero.

All pins are plain control and status levels or pulses. No data moves through the block, so there is no valid/ready interface and no back-pressure.

Top module: `dma_req_gate`

## Requirements
- R1: In idle, a `xfer_req_i` pulse with a nonzero `xfer_blocks_i` latches the count. From the next cycle `busy_o` is 1 and `blocks_left_o` equals the count, and `bus_req_o` is 1 in that same cycle when no hold is active. A strobe with a zero count, or any strobe while `busy_o` is 1, is ignored.
- R2: A sampled `bus_grant_i` while `bus_req_o` is 1 starts the transfer. From then on `bus_req_o` stays 1 until a `block_done_i` pulse, and each such pulse lowers `blocks_left_o` by one. In the cycle after the last block's pulse, `busy_o`, `bus_req_o` and `blocks_left_o` are all 0.
- R3: A hold is qualifying when `nmi_i` is 1, or when `irq_pend_i` is 1 and `irq_level_i` is numerically smaller than `hold_lvl_i` (a smaller value is more urgent; equal does not qualify). While a block is in flight, a qualifying hold removes `bus_req_o` only in the cycle after a non-last `block_done_i`. Before the grant, a qualifying hold removes `bus_req_o` in the same cycle.
- R4: While the request is held, `busy_o` stays 1 and `blocks_left_o` is unchanged. When the hold ends, `bus_req_o` returns to 1 in the same cycle, and the transfer resumes on the next grant.
- R5: While `sup_val_o` is nonzero, no bus request is raised for a latched request that is not in flight. The request is released in the same cycle `sup_val_o` reads 0.
- R6: A cycle with `sup_inc_i` alone adds one to `sup_val_o`, and a cycle with `sup_dec_i` alone subtracts one. Both together leave the counter unchanged.
- R7: An increment at 15 keeps 15 and sets the sticky `sup_ovf_o`. A decrement at 0 keeps 0. A direct write clears `sup_ovf_o`.
- R8: A `sup_wr_i` cycle loads `sup_wdata_i` and takes priority over an increment or decrement in the same cycle.
- R9: After reset, `busy_o`, `bus_req_o`, `held_o`, `sup_val_o` and `sup_ovf_o` are 0. `held_o` is 1 exactly while a request is latched but not requesting because of either hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_req_i | input | 1 | Pending-transfer strobe |
| xfer_blocks_i | input | BLK_W | Block count sampled with the strobe |
| bus_grant_i | input | 1 | Bus grant from the bus controller |
| block_done_i | input | 1 | One-cycle pulse at the end of each block |
| nmi_i | input | 1 | Non-maskable interrupt pending |
| irq_pend_i | input | 1 | A maskable interrupt is pending |
| irq_level_i | input | LVL_W | Level of the pending interrupt, smaller is more urgent |
| hold_lvl_i | input | LVL_W | Hold threshold level |
| sup_wr_i | input | 1 | Direct write of the suppress counter |
| sup_wdata_i | input | SUP_W | Value for the direct write |
| sup_inc_i | input | 1 | Increment suppress counter by one |
| sup_dec_i | input | 1 | Decrement suppress counter by one |
| bus_req_o | output | 1 | Bus request to the bus controller |
| busy_o | output | 1 | A request is latched and not finished |
| held_o | output | 1 | A latched request is blocked by a hold |
| blocks_left_o | output | BLK_W | Blocks still to transfer |
| sup_val_o | output | SUP_W | Suppress counter value |
| sup_ovf_o | output | 1 | Sticky: an increment was attempted at 15 |

## Verification
Two events can fall in the same cycle: the end of a block and the start of a qualifying hold. The bench provokes this on a non-last block and judges that the request moves to held with one block fewer. It also provokes it on the last block and judges that the transfer ends cleanly and is not parked as held. A second coincidence is a direct suppress write together with an increment or decrement. This is provoked in both directions, and the written value must win, while a simultaneous increment and decrement must leave the counter as it was.

// File: rtl/dmg_pkg.sv
package dmg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_XFER = 2'd2
  } dmg_state_e;
endpackage

// File: rtl/dmg_hold_qual.sv
module dmg_hold_qual #(
  parameter int LVL_W = 5,
  parameter int SUP_W = 4
) (
  input  logic             nmi_i,
  input  logic             irq_pend_i,
  input  logic [LVL_W-1:0] irq_level_i,
  input  logic [LVL_W-1:0] hold_lvl_i,
  input  logic [SUP_W-1:0] sup_val_i,
  output logic             irq_hold_o,
  output logic             hold_o
);
  logic urgent;

  // smaller level value means more urgent; equal does not qualify
  assign urgent     = irq_pend_i && (irq_level_i < hold_lvl_i);
  assign irq_hold_o = nmi_i || urgent;
  assign hold_o     = irq_hold_o || (sup_val_i != '0);
endmodule

// File: rtl/dmg_suppress_ctr.sv
module dmg_suppress_ctr #(
  parameter int SUP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [SUP_W-1:0] wdata_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [SUP_W-1:0] val_o,
  output logic             ovf_o
);
  localparam logic [SUP_W-1:0] MAXV = {SUP_W{1'b1}};

  logic [SUP_W-1:0] val_q, val_d;
  logic             ovf_q, ovf_d;

  always_comb begin
    val_d = val_q;
    ovf_d = ovf_q;
    if (wr_i) begin
      val_d = wdata_i;
      ovf_d = 1'b0;
    end else if (inc_i && !dec_i) begin
      if (val_q == MAXV) ovf_d = 1'b1;
      else               val_d = val_q + 1'b1;
    end else if (dec_i && !inc_i) begin
      if (val_q != '0) val_d = val_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      val_q <= val_d;
      ovf_q <= ovf_d;
    end
  end

  assign val_o = val_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/dmg_req_fsm.sv
module dmg_req_fsm
  import dmg_pkg::*;
#(
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_req_i,
  input  logic [BLK_W-1:0] xfer_blocks_i,
  input  logic             bus_grant_i,
  input  logic             block_done_i,
  input  logic             hold_i,
  output logic             bus_req_o,
  output logic             busy_o,
  output logic             held_o,
  output logic [BLK_W-1:0] blocks_left_o
);
  localparam logic [BLK_W-1:0] ONE = BLK_W'(1);

  dmg_state_e       st_q, st_d;
  logic [BLK_W-1:0] left_q, left_d;
  logic             req_c;

  // in flight the request is kept; while pending it follows the hold
  assign req_c = (st_q == ST_XFER) || ((st_q == ST_PEND) && !hold_i);

  always_comb begin
    st_d   = st_q;
    left_d = left_q;
    unique case (st_q)
      ST_IDLE: begin
        if (xfer_req_i && (xfer_blocks_i != '0)) begin
          st_d   = ST_PEND;
          left_d = xfer_blocks_i;
        end
      end
      ST_PEND: begin
        if (req_c && bus_grant_i) st_d = ST_XFER;
      end
      ST_XFER: begin
        if (block_done_i) begin
          left_d = left_q - ONE;
          if (left_q == ONE) st_d = ST_IDLE;
          else if (hold_i)   st_d = ST_PEND;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      left_q <= '0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
    end
  end

  assign bus_req_o     = req_c;
  assign busy_o        = (st_q != ST_IDLE);
  assign held_o        = (st_q == ST_PEND) && hold_i;
  assign blocks_left_o = left_q;
endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate #(
  parameter int BLK_W = 8,
  parameter int LVL_W = 5,
  parameter int SUP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_req_i,
  input  logic [BLK_W-1:0] xfer_blocks_i,
  input  logic             bus_grant_i,
  input  logic             block_done_i,
  input  logic             nmi_i,
  input  logic             irq_pend_i,
  input  logic [LVL_W-1:0] irq_level_i,
  input  logic [LVL_W-1:0] hold_lvl_i,
  input  logic             sup_wr_i,
  input  logic [SUP_W-1:0] sup_wdata_i,
  input  logic             sup_inc_i,
  input  logic             sup_dec_i,
  output logic             bus_req_o,
  output logic             busy_o,
  output logic             held_o,
  output logic [BLK_W-1:0] blocks_left_o,
  output logic [SUP_W-1:0] sup_val_o,
  output logic             sup_ovf_o
);
  logic [SUP_W-1:0] sup_val;
  logic             irq_hold;
  logic             hold;

  dmg_suppress_ctr #(.SUP_W(SUP_W)) u_sup (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (sup_wr_i),
    .wdata_i (sup_wdata_i),
    .inc_i   (sup_inc_i),
    .dec_i   (sup_dec_i),
    .val_o   (sup_val),
    .ovf_o   (sup_ovf_o)
  );

  dmg_hold_qual #(.LVL_W(LVL_W), .SUP_W(SUP_W)) u_qual (
    .nmi_i       (nmi_i),
    .irq_pend_i  (irq_pend_i),
    .irq_level_i (irq_level_i),
    .hold_lvl_i  (hold_lvl_i),
    .sup_val_i   (sup_val),
    .irq_hold_o  (irq_hold),
    .hold_o      (hold)
  );

  dmg_req_fsm #(.BLK_W(BLK_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .xfer_req_i    (xfer_req_i),
    .xfer_blocks_i (xfer_blocks_i),
    .bus_grant_i   (bus_grant_i),
    .block_done_i  (block_done_i),
    .hold_i        (hold),
    .bus_req_o     (bus_req_o),
    .busy_o        (busy_o),
    .held_o        (held_o),
    .blocks_left_o (blocks_left_o)
  );

  assign sup_val_o = sup_val;
endmodule

// File: rtl/dma_req_gate_chk.sv
module dma_req_gate_chk #(
  parameter int BLK_W = 8,
  parameter int LVL_W = 5,
  parameter int SUP_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_req_i,
  input logic             bus_grant_i,
  input logic             block_done_i,
  input logic             sup_wr_i,
  input logic [SUP_W-1:0] sup_wdata_i,
  input logic             sup_inc_i,
  input logic             sup_dec_i,
  input logic             bus_req_o,
  input logic             busy_o,
  input logic             held_o,
  input logic [SUP_W-1:0] sup_val_o,
  input logic             sup_ovf_o
);
  localparam logic [SUP_W-1:0] MAXV = {SUP_W{1'b1}};

  // tracks a granted block in flight, from the port view only
  logic granted_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) granted_q <= 1'b0;
    else        granted_q <= bus_req_o && (bus_grant_i || granted_q) && !block_done_i;
  end

  assert_busy_from_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(xfer_req_i));

  assert_no_mid_block_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (granted_q && !block_done_i) |=> bus_req_o);

  assert_suppress_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !granted_q && (sup_val_o != '0)) |-> !bus_req_o);

  assert_inc_dec_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_inc_i && sup_dec_i && !sup_wr_i) |=> $stable(sup_val_o));

  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_inc_i && !sup_dec_i && !sup_wr_i && (sup_val_o == MAXV)) |=> (sup_val_o == MAXV) && sup_ovf_o);

  assert_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_dec_i && !sup_inc_i && !sup_wr_i && (sup_val_o == '0)) |=> (sup_val_o == '0));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sup_wr_i |=> (sup_val_o == $past(sup_wdata_i)));

  assert_held_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    held_o |-> (busy_o && !bus_req_o));
endmodule

bind dma_req_gate dma_req_gate_chk #(.BLK_W(BLK_W), .LVL_W(LVL_W), .SUP_W(SUP_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .xfer_req_i   (xfer_req_i),
  .bus_grant_i  (bus_grant_i),
  .block_done_i (block_done_i),
  .sup_wr_i     (sup_wr_i),
  .sup_wdata_i  (sup_wdata_i),
  .sup_inc_i    (sup_inc_i),
  .sup_dec_i    (sup_dec_i),
  .bus_req_o    (bus_req_o),
  .busy_o       (busy_o),
  .held_o       (held_o),
  .sup_val_o    (sup_val_o),
  .sup_ovf_o    (sup_ovf_o)
);

// File: tb/dma_req_gate_tb_top.sv
module dma_req_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BLK_W = 8;
  localparam int LVL_W = 5;
  localparam int SUP_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             xfer_req;
  logic [BLK_W-1:0] xfer_blocks;
  logic             bus_grant;
  logic             block_done;
  logic             nmi;
  logic             irq_pend;
  logic [LVL_W-1:0] irq_level;
  logic [LVL_W-1:0] hold_lvl;
  logic             sup_wr;
  logic [SUP_W-1:0] sup_wdata;
  logic             sup_inc;
  logic             sup_dec;
  logic             bus_req;
  logic             busy;
  logic             held;
  logic [BLK_W-1:0] blocks_left;
  logic [SUP_W-1:0] sup_val;
  logic             sup_ovf;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_gate #(.BLK_W(BLK_W), .LVL_W(LVL_W), .SUP_W(SUP_W)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .xfer_req_i (xfer_req), .xfer_blocks_i (xfer_blocks),
    .bus_grant_i (bus_grant), .block_done_i (block_done),
    .nmi_i (nmi), .irq_pend_i (irq_pend), .irq_level_i (irq_level),
    .hold_lvl_i (hold_lvl),
    .sup_wr_i (sup_wr), .sup_wdata_i (sup_wdata),
    .sup_inc_i (sup_inc), .sup_dec_i (sup_dec),
    .bus_req_o (bus_req), .busy_o (busy), .held_o (held),
    .blocks_left_o (blocks_left), .sup_val_o (sup_val), .sup_ovf_o (sup_ovf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // advance one edge and settle away from it
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic start(input int n);
    xfer_req = 1'b1; xfer_blocks = BLK_W'(n);
    tick();
    xfer_req = 1'b0; xfer_blocks = '0;
  endtask

  task automatic block();
    block_done = 1'b1;
    tick();
    block_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 reset busy", busy, 0);
    chk("R9 reset bus_req", bus_req, 0);
    chk("R9 reset held", held, 0);
    chk("R9 reset sup_val", sup_val, 0);
    chk("R9 reset sup_ovf", sup_ovf, 0);
  endtask

  task automatic t_basic();
    start(3);
    chk("R1 busy after strobe", busy, 1);
    chk("R1 bus_req after strobe", bus_req, 1);
    chk("R1 blocks latched", blocks_left, 3);
    bus_grant = 1'b1; tick();
    block();
    chk("R2 count after block", blocks_left, 2);
    chk("R2 req kept between blocks", bus_req, 1);
    block(); block();
    chk("R2 busy after last", busy, 0);
    chk("R2 req after last", bus_req, 0);
    chk("R2 count after last", blocks_left, 0);
    bus_grant = 1'b0;
  endtask

  task automatic t_irq_hold();
    start(3);
    bus_grant = 1'b1; tick();
    irq_pend = 1'b1; irq_level = 5'd3;
    tick();
    chk("R3 no drop mid block", bus_req, 1);
    block();
    bus_grant = 1'b0;
    chk("R3 drop at boundary", bus_req, 0);
    chk("R9 held during irq", held, 1);
    tick(); tick();
    chk("R4 busy retained", busy, 1);
    chk("R4 count retained", blocks_left, 2);
    irq_pend = 1'b0; #1;
    chk("R4 req back on release", bus_req, 1);
    chk("R9 held cleared", held, 0);
    bus_grant = 1'b1; tick();
    block(); block();
    chk("R4 resumed to completion", busy, 0);
    bus_grant = 1'b0;
  endtask

  task automatic t_equal_level();
    irq_pend = 1'b1; irq_level = 5'd8;
    start(1);
    chk("R3 equal level not qualifying", bus_req, 1);
    irq_level = 5'd9; #1;
    chk("R3 less urgent not qualifying", bus_req, 1);
    bus_grant = 1'b1; tick();
    block();
    bus_grant = 1'b0; irq_pend = 1'b0;
    chk("R2 single block done", busy, 0);
  endtask

  task automatic t_nmi_pre_grant();
    hold_lvl = 5'd0;
    start(2);
    nmi = 1'b1; #1;
    chk("R3 nmi drops req before grant", bus_req, 0);
    chk("R3 nmi held", held, 1);
    nmi = 1'b0; #1;
    chk("R4 req after nmi", bus_req, 1);
    hold_lvl = 5'd8;
    bus_grant = 1'b1; tick();
    block(); block();
    bus_grant = 1'b0;
  endtask

  task automatic t_suppress();
    sup_inc = 1'b1; tick(); tick(); sup_inc = 1'b0;
    chk("R6 nested inc", sup_val, 2);
    start(1);
    chk("R5 suppressed no req", bus_req, 0);
    chk("R5 suppressed held", held, 1);
    sup_dec = 1'b1; tick();
    chk("R6 dec one", sup_val, 1);
    chk("R5 still suppressed", bus_req, 0);
    tick(); sup_dec = 1'b0;
    chk("R5 counter zero", sup_val, 0);
    chk("R5 req same cycle zero", bus_req, 1);
    bus_grant = 1'b1; tick();
    block();
    bus_grant = 1'b0;
  endtask

  task automatic t_saturate();
    sup_wr = 1'b1; sup_wdata = 4'd14; tick(); sup_wr = 1'b0;
    sup_inc = 1'b1; tick();
    chk("R7 reach 15", sup_val, 15);
    chk("R7 no ovf yet", sup_ovf, 0);
    tick(); sup_inc = 1'b0;
    chk("R7 saturate", sup_val, 15);
    chk("R7 ovf sticky", sup_ovf, 1);
    tick();
    chk("R7 ovf held", sup_ovf, 1);
    sup_wr = 1'b1; sup_wdata = 4'd0; tick(); sup_wr = 1'b0;
    chk("R7 write clears ovf", sup_ovf, 0);
    sup_dec = 1'b1; tick(); sup_dec = 1'b0;
    chk("R7 floor at zero", sup_val, 0);
  endtask

  task automatic t_priority();
    sup_wr = 1'b1; sup_wdata = 4'd5; sup_inc = 1'b1; tick();
    chk("R8 write beats inc", sup_val, 5);
    sup_wdata = 4'd2; sup_inc = 1'b0; sup_dec = 1'b1; tick();
    chk("R8 write beats dec", sup_val, 2);
    sup_wr = 1'b0; sup_inc = 1'b1; tick();
    sup_inc = 1'b0; sup_dec = 1'b0;
    chk("R6 inc and dec cancel", sup_val, 2);
    sup_wr = 1'b1; sup_wdata = 4'd0; tick(); sup_wr = 1'b0;
  endtask

  task automatic t_ignore();
    start(0);
    chk("R1 zero count ignored", busy, 0);
    start(2);
    bus_grant = 1'b1; tick();
    start(9);
    chk("R1 strobe while busy ignored", blocks_left, 2);
    block(); block();
    bus_grant = 1'b0;
    chk("R1 original count finished", busy, 0);
  endtask

  task automatic t_coincide();
    start(2);
    bus_grant = 1'b1; tick();
    irq_pend = 1'b1; irq_level = 5'd1;
    block();
    bus_grant = 1'b0;
    chk("R3 hold at boundary held", held, 1);
    chk("R4 count after coincident block", blocks_left, 1);
    irq_pend = 1'b0;
    bus_grant = 1'b1; tick();
    irq_pend = 1'b1;
    block();
    bus_grant = 1'b0;
    chk("R2 last block with hold ends", busy, 0);
    chk("R9 not held after end", held, 0);
    irq_pend = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; xfer_req = 1'b0; xfer_blocks = '0; bus_grant = 1'b0;
    block_done = 1'b0; nmi = 1'b0; irq_pend = 1'b0; irq_level = '0;
    hold_lvl = 5'd8; sup_wr = 1'b0; sup_wdata = '0; sup_inc = 1'b0; sup_dec = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_irq_hold();
    t_equal_level();
    t_nmi_pre_grant();
    t_suppress();
    t_saturate();
    t_priority();
    t_ignore();
    t_coincide();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule